// File: doc/BRIEF.md
# Pin Function Select Register Bank

This block holds the function selection for one bank of 32 pins. The pins form four groups of eight. Each group is set at elaboration to one of four kinds: a 2-bit selector per pin, a 3-bit selector per pin, a 4-bit selector per pin, or a group that can only act as plain GPIO. A separate parameter can mark any group as unrouted. Software reaches the selectors through a single-cycle register port. Every pin's current selector is driven on a wide output that the pad logic next to the block decodes.

A write carries its own bit-enable mask. The upper half-word of the write data names the bits of the lower half-word that the write changes. Single fields can therefore be updated without first reading the register. Groups with 3-bit or 4-bit selectors need more than sixteen bits, so each of them spans two consecutive registers. A group with 2-bit selectors, and a GPIO-only group, each take one register. Every request gets a response on the following cycle. The response carries read data, a decode-error flag or a not-supported flag.

Top module: `pinmux_bank`

## Requirements
- R1: While reset is asserted and just after it is released, every pin selector is 0, which means plain GPIO, and no response is pending.
- R2: In a 2-bit group, pin p (p = pin mod 8) uses bits [2p+1:2p] of the group's only register.
- R3: In a 3-bit group, pins 0..4 use bits [3p+2:3p] of the group's first register. Pins 5..7 use bits [3(p-5)+2:3(p-5)] of the second register. Bits with no field behind them always read 0: bit 15 of the first register and bits 15:9 of the second.
- R4: In a 4-bit group, pins 0..3 use bits [4p+3:4p] of the first register and pins 4..7 use bits [4(p-4)+3:4(p-4)] of the second.
- R5: A write changes bit i of the lower half-word (i in 0..15) only when bit 16+i of the write data is 1. Every other bit keeps its value.
- R6: A request presented in cycle n produces rsp_valid in cycle n+1. A read returns the register image in bits 15:0 and zeros in bits 31:16. Writes and failed accesses return 0.
- R7: Registers are 4 bytes apart and start at byte address 0. Group 0 comes first, then groups 1, 2 and 3 in rising order. 3-bit and 4-bit groups take two registers each; 2-bit and GPIO-only groups take one.
- R8: A GPIO-only group always shows selector 0 on its pins. Writes to its register are accepted without error but have no effect, and reads of it return 0.
- R9: An access to a register of an unrouted group raises rsp_unsup for one cycle, returns data 0 and changes no selector.
- R10: An access with a non-zero byte offset, or to an address beyond the last register, raises rsp_err for one cycle and changes no state.
- R11: Pin k's selector appears on pin_func[4k+3:4k], zero-extended, and changes only on the clock edge that accepts a write to its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | [31:16] bit-enable mask, [15:0] data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, upper half always 0 |
| rsp_err | output | 1 | Address decoded to no register |
| rsp_unsup | output | 1 | Address belongs to an unrouted group |
| pin_func | output | 128 | Per-pin selectors, 4 bits per pin |

## Verification
The same edge can carry two events: a write's response, and the pin selector change that the write causes on pad outputs the next stage is already sampling. The next request can also be a read of the register just written, and that read must see the new image. A long stream of back-to-back requests provokes both cases. The stream uses random addresses, including misaligned and out-of-map ones, and random masks. A behavioural reference is checked against the responses and all 128 selector bits on every clock. Two instances receive the same stream and differ only in which groups are unrouted. The bench therefore also judges a single request that is accepted by one instance and refused as unsupported by the other.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

   localparam int GROUPS       = 4;
   localparam int PINS_PER_GRP = 8;
   localparam int NUM_PINS     = GROUPS * PINS_PER_GRP;
   localparam int FUNC_W       = 4;
   localparam int HALF_W       = 16;

   typedef enum logic [1:0] {
      MODE_W2   = 2'd0,
      MODE_W3   = 2'd1,
      MODE_W4   = 2'd2,
      MODE_GPIO = 2'd3
   } grp_mode_e;

   // registers occupied by one group
   function automatic int words_of(input logic [1:0] mode);
      return (mode == MODE_W3 || mode == MODE_W4) ? 2 : 1;
   endfunction

   // word index of a group's first register
   function automatic int first_word(input logic [2*GROUPS-1:0] modes, input int grp);
      int acc;
      acc = 0;
      for (int g = 0; g < grp; g++) acc += words_of(modes[2*g +: 2]);
      return acc;
   endfunction

   // bits that carry a field in register half (0 = first, 1 = second)
   function automatic logic [HALF_W-1:0] impl_mask(input logic [1:0] mode, input int half);
      case (mode)
         MODE_W2: return (half == 0) ? 16'hFFFF : 16'h0000;
         MODE_W3: return (half == 0) ? 16'h7FFF : 16'h01FF;
         MODE_W4: return 16'hFFFF;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic int field_width(input logic [1:0] mode);
      case (mode)
         MODE_W2: return 2;
         MODE_W3: return 3;
         MODE_W4: return 4;
         default: return 0;
      endcase
   endfunction

   function automatic int field_half(input logic [1:0] mode, input int pin);
      case (mode)
         MODE_W3: return (pin >= 5) ? 1 : 0;
         MODE_W4: return (pin >= 4) ? 1 : 0;
         default: return 0;
      endcase
   endfunction

   function automatic int field_lsb(input logic [1:0] mode, input int pin);
      case (mode)
         MODE_W2: return 2 * pin;
         MODE_W3: return 3 * (pin % 5);
         MODE_W4: return 4 * (pin % 4);
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/pinmux_decode.sv
module pinmux_decode
   import pinmux_pkg::*;
#(
   parameter int                    ADDR_W      = 8,
   parameter logic [2*GROUPS-1:0]   GROUP_MODES = 8'b11_10_01_00
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [GROUPS-1:0] grp_hit,
   output logic              hi_sel,
   output logic              addr_ok
);

   logic              aligned;
   logic [31:0]       word_i;
   logic [GROUPS-1:0] hi_g;

   assign aligned = (addr[1:0] == 2'b00);
   assign word_i  = 32'(addr[ADDR_W-1:2]);

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      localparam int FIRST = first_word(GROUP_MODES, g);
      localparam int NW    = words_of(GROUP_MODES[2*g +: 2]);
      // unsigned wrap keeps the range test to one compare
      assign grp_hit[g] = aligned && ((word_i - 32'(FIRST)) < 32'(NW));
      if (NW == 2) begin : g_two
         assign hi_g[g] = (word_i == 32'(FIRST + 1));
      end else begin : g_one
         assign hi_g[g] = 1'b0;
      end
   end

   assign hi_sel  = |(hi_g & grp_hit);
   assign addr_ok = |grp_hit;

endmodule

// File: rtl/pinmux_group.sv
module pinmux_group
   import pinmux_pkg::*;
#(
   parameter logic [1:0] MODE = MODE_W2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [1:0]                     wr_en,
   input  logic [HALF_W-1:0]              wr_data,
   input  logic [HALF_W-1:0]              wr_mask,
   output logic [1:0][HALF_W-1:0]         image,
   output logic [PINS_PER_GRP*FUNC_W-1:0] funcs
);

   localparam int FW = field_width(MODE);

   for (genvar h = 0; h < 2; h++) begin : g_half
      localparam logic [HALF_W-1:0] IMPL = impl_mask(MODE, h);
      logic [HALF_W-1:0] store_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            store_q <= '0;
         else if (wr_en[h])
            store_q <= ((store_q & ~wr_mask) | (wr_data & wr_mask)) & IMPL;
      end

      assign image[h] = store_q;
   end

   for (genvar p = 0; p < PINS_PER_GRP; p++) begin : g_pin
      if (FW == 0) begin : g_gpio
         assign funcs[p*FUNC_W +: FUNC_W] = '0;
      end else begin : g_fld
         localparam int H = field_half(MODE, p);
         localparam int L = field_lsb(MODE, p);
         if (FW < FUNC_W) begin : g_ext
            assign funcs[p*FUNC_W +: FUNC_W] = {{(FUNC_W-FW){1'b0}}, image[H][L +: FW]};
         end else begin : g_full
            assign funcs[p*FUNC_W +: FUNC_W] = image[H][L +: FW];
         end
      end
   end

endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
   import pinmux_pkg::*;
#(
   parameter int                  ADDR_W      = 8,
   parameter logic [2*GROUPS-1:0] GROUP_MODES = 8'b11_10_01_00,
   parameter logic [GROUPS-1:0]   UNROUTED    = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic                       req_write,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [31:0]                req_wdata,
   output logic                       rsp_valid,
   output logic [31:0]                rsp_rdata,
   output logic                       rsp_err,
   output logic                       rsp_unsup,
   output logic [NUM_PINS*FUNC_W-1:0] pin_func
);

   localparam int GRP_BITS  = PINS_PER_GRP * FUNC_W;
   localparam int MAP_WORDS = first_word(GROUP_MODES, GROUPS);

   if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr_w
      $error("pinmux_bank: ADDR_W must lie in 5..32");
   end
   if (MAP_WORDS < GROUPS || MAP_WORDS > 2*GROUPS) begin : g_bad_map
      $error("pinmux_bank: register map size out of range");
   end

   logic [GROUPS-1:0] grp_hit;
   logic              hi_sel;
   logic              addr_ok;

   pinmux_decode #(
      .ADDR_W     (ADDR_W),
      .GROUP_MODES(GROUP_MODES)
   ) u_dec (
      .addr   (req_addr),
      .grp_hit(grp_hit),
      .hi_sel (hi_sel),
      .addr_ok(addr_ok)
   );

   logic acc, unr_hit, wr_ok, rd_ok;

   assign acc     = req_valid && addr_ok;
   assign unr_hit = |(grp_hit & UNROUTED);
   assign wr_ok   = acc && req_write && !unr_hit;
   assign rd_ok   = acc && !req_write && !unr_hit;

   logic [GROUPS-1:0][1:0][HALF_W-1:0] grp_img;

   for (genvar g = 0; g < GROUPS; g++) begin : g_bank
      logic [1:0] wen;
      assign wen[0] = wr_ok && grp_hit[g] && !hi_sel;
      assign wen[1] = wr_ok && grp_hit[g] &&  hi_sel;

      pinmux_group #(
         .MODE(GROUP_MODES[2*g +: 2])
      ) u_grp (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wen),
         .wr_data(req_wdata[HALF_W-1:0]),
         .wr_mask(req_wdata[2*HALF_W-1:HALF_W]),
         .image  (grp_img[g]),
         .funcs  (pin_func[g*GRP_BITS +: GRP_BITS])
      );
   end

   logic [HALF_W-1:0] rd_img;

   always_comb begin
      rd_img = '0;
      for (int g = 0; g < GROUPS; g++) begin
         if (grp_hit[g]) rd_img = rd_img | grp_img[g][hi_sel];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
         rsp_unsup <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && !addr_ok;
         rsp_unsup <= acc && unr_hit;
         rsp_rdata <= rd_ok ? {{HALF_W{1'b0}}, rd_img} : '0;
      end
   end

endmodule

// File: rtl/pinmux_bank_chk.sv
module pinmux_bank_chk
   import pinmux_pkg::*;
#(
   parameter logic [2*GROUPS-1:0] GROUP_MODES = 8'b11_10_01_00
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       req_valid,
   input logic                       req_write,
   input logic                       rsp_valid,
   input logic [31:0]                rsp_rdata,
   input logic                       rsp_err,
   input logic                       rsp_unsup,
   input logic [NUM_PINS*FUNC_W-1:0] pin_func
);

   assert_rsp_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_no_spurious_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_upper_half_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_rdata[31:16] == 16'h0));

   assert_err_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && !rsp_unsup && rsp_rdata == 32'h0));

   assert_err_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $stable(pin_func));

   assert_unsup_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_unsup |-> ($stable(pin_func) && rsp_rdata == 32'h0));

   assert_idle_holds_funcs_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> $stable(pin_func));

   for (genvar g = 0; g < GROUPS; g++) begin : g_chk
      localparam logic [1:0] M = GROUP_MODES[2*g +: 2];
      for (genvar p = 0; p < PINS_PER_GRP; p++) begin : g_pin
         localparam int K = g*PINS_PER_GRP + p;
         if (M == MODE_GPIO) begin : g_gpio
            assert_gpio_only_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
               pin_func[K*FUNC_W +: FUNC_W] == '0);
         end else if (M == MODE_W3) begin : g_w3
            assert_w3_field_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
               pin_func[K*FUNC_W + 3] == 1'b0);
         end else if (M == MODE_W2) begin : g_w2
            assert_w2_field_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
               pin_func[K*FUNC_W+2 +: 2] == 2'b00);
         end
      end
   end

endmodule

bind pinmux_bank pinmux_bank_chk #(
   .GROUP_MODES(GROUP_MODES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_write(req_write),
   .rsp_valid(rsp_valid),
   .rsp_rdata(rsp_rdata),
   .rsp_err  (rsp_err),
   .rsp_unsup(rsp_unsup),
   .pin_func (pin_func)
);

// File: tb/pinmux_bank_test.sv
`timescale 1ns/1ps
module pinmux_bank_test;

   localparam logic [7:0] MODES = 8'b11_10_01_00;   // g0 2-bit, g1 3-bit, g2 4-bit, g3 GPIO-only
   localparam logic [3:0] UNR_B = 4'b0010;          // second instance: group 1 unrouted

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n     = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr  = '0;
   logic [31:0] req_wdata = '0;

   logic         rv   [2];
   logic [31:0]  rd   [2];
   logic         re   [2];
   logic         ru   [2];
   logic [127:0] pf   [2];

   pinmux_bank #(.ADDR_W(8), .GROUP_MODES(MODES), .UNROUTED(4'b0000)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv[0]), .rsp_rdata(rd[0]),
      .rsp_err(re[0]), .rsp_unsup(ru[0]), .pin_func(pf[0]));

   pinmux_bank #(.ADDR_W(8), .GROUP_MODES(MODES), .UNROUTED(UNR_B)) uut_u (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv[1]), .rsp_rdata(rd[1]),
      .rsp_err(re[1]), .rsp_unsup(ru[1]), .pin_func(pf[1]));

   int    checks = 0;
   int    fails  = 0;
   string cur_tag = "R1";
   bit    started = 1'b0;

   // reference state: one selector value per pin per instance
   int          fn     [2][32];
   logic        exp_v  [2];
   logic        exp_e  [2];
   logic        exp_u  [2];
   logic [31:0] exp_rd [2];

   initial begin
      for (int i = 0; i < 2; i++) begin
         exp_v[i] = 0; exp_e[i] = 0; exp_u[i] = 0; exp_rd[i] = 0;
         for (int k = 0; k < 32; k++) fn[i][k] = 0;
      end
   end

   function automatic int mode_of(input int g);
      return int'(MODES[2*g +: 2]);
   endfunction

   // field placement taken from R2, R3, R4
   function automatic void fmap(input int mode, input int p, output int half, output int lsb, output int wid);
      half = 0; lsb = 0; wid = 0;
      if (mode == 0) begin wid = 2; lsb = 2*p; end
      else if (mode == 1) begin
         wid = 3;
         if (p < 5) lsb = 3*p; else begin half = 1; lsb = 3*(p-5); end
      end else if (mode == 2) begin
         wid = 4; half = p / 4; lsb = 4*(p % 4);
      end
   endfunction

   always @(posedge clk) begin
      for (int i = 0; i < 2; i++) begin
         if (!rst_n) begin
            exp_v[i] = 0; exp_e[i] = 0; exp_u[i] = 0; exp_rd[i] = 0;
            for (int k = 0; k < 32; k++) fn[i][k] = 0;
         end else begin
            int word, grp, half, start, nw, h, l, w, pin;
            logic [3:0] unr;
            unr = (i == 1) ? UNR_B : 4'b0000;
            exp_v[i] = req_valid; exp_e[i] = 0; exp_u[i] = 0; exp_rd[i] = 0;
            if (req_valid) begin
               word = int'(req_addr) / 4; grp = -1; half = 0; start = 0;
               for (int g = 0; g < 4; g++) begin
                  nw = (mode_of(g) == 1 || mode_of(g) == 2) ? 2 : 1;
                  if (word >= start && word < start + nw) begin grp = g; half = word - start; end
                  start += nw;
               end
               if (req_addr[1:0] != 2'b00 || grp < 0) exp_e[i] = 1;
               else if (unr[grp]) exp_u[i] = 1;
               else if (mode_of(grp) != 3) begin
                  for (int p = 0; p < 8; p++) begin
                     fmap(mode_of(grp), p, h, l, w);
                     pin = grp*8 + p;
                     if (h == half) begin
                        for (int b = 0; b < w; b++) begin
                           if (req_write) begin
                              if (req_wdata[16+l+b])
                                 fn[i][pin] = req_wdata[l+b] ? (fn[i][pin] | (1 << b)) : (fn[i][pin] & ~(1 << b));
                           end else begin
                              exp_rd[i][l+b] = fn[i][pin][b];
                           end
                        end
                     end
                  end
               end
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         for (int i = 0; i < 2; i++) begin
            logic [127:0] want;
            for (int k = 0; k < 32; k++) want[4*k +: 4] = 4'(fn[i][k]);
            chk(pf[i] == want, {"R11/", cur_tag}, $sformatf("pin_func inst%0d", i), pf[i], want);
            chk(rv[i] == exp_v[i], "R6", $sformatf("rsp_valid inst%0d", i), 128'(rv[i]), 128'(exp_v[i]));
            chk(rd[i] == exp_rd[i], cur_tag, $sformatf("rsp_rdata inst%0d", i), 128'(rd[i]), 128'(exp_rd[i]));
            chk(re[i] == exp_e[i], "R10", $sformatf("rsp_err inst%0d", i), 128'(re[i]), 128'(exp_e[i]));
            chk(ru[i] == exp_u[i], "R9", $sformatf("rsp_unsup inst%0d", i), 128'(ru[i]), 128'(exp_u[i]));
         end
      end
   end

   task automatic access(input bit w, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         req_valid = 1'b0; req_write = 1'b0;
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state observed at the ports
      chk(pf[0] == '0 && pf[1] == '0, "R1", "pin_func in reset", pf[0] | pf[1], '0);
      chk(rv[0] == 1'b0 && rv[1] == 1'b0, "R1", "rsp_valid in reset", 128'(rv[0] | rv[1]), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pf[0] == '0, "R1", "pin_func after reset", pf[0], '0);
      started = 1'b1;

      cur_tag = "R2";
      access(1, 8'h00, 32'hFFFF_A5C3);
      access(0, 8'h00, 32'h0);
      cur_tag = "R5";
      access(1, 8'h00, 32'h0F00_0000);
      access(1, 8'h00, 32'h00F0_0000);
      access(1, 8'h00, 32'h0003_FFFC);
      access(0, 8'h00, 32'h0);
      cur_tag = "R3";
      access(1, 8'h04, 32'hFFFF_FFFF);
      access(1, 8'h08, 32'hFFFF_FFFF);
      access(0, 8'h04, 32'h0);
      access(0, 8'h08, 32'h0);
      access(1, 8'h04, 32'hFFFF_4D2A);
      access(1, 8'h08, 32'h01C0_0000);
      access(0, 8'h04, 32'h0);
      access(0, 8'h08, 32'h0);
      idle(2);
      chk(pf[1][63:32] == 32'h0, "R9", "unrouted group selectors", 128'(pf[1][63:32]), '0);
      cur_tag = "R4";
      access(1, 8'h0C, 32'hFFFF_1234);
      access(1, 8'h10, 32'hFFFF_CDEF);
      access(1, 8'h10, 32'hF000_0000);
      access(0, 8'h0C, 32'h0);
      access(0, 8'h10, 32'h0);
      cur_tag = "R8";
      access(1, 8'h14, 32'hFFFF_FFFF);
      access(0, 8'h14, 32'h0);
      cur_tag = "R10";
      access(1, 8'h18, 32'hFFFF_FFFF);
      access(0, 8'h1C, 32'h0);
      access(1, 8'h02, 32'hFFFF_0000);
      access(0, 8'h81, 32'h0);
      access(1, 8'hFC, 32'hFFFF_FFFF);
      cur_tag = "R7";
      for (int a = 0; a < 6; a++) access(0, 8'(4*a), 32'h0);
      idle(1);
      cur_tag = "R6";
      for (int n = 0; n < 600; n++) begin
         if ($urandom_range(0, 4) == 0) idle(1);
         else access(1'($urandom_range(0, 1)), 8'($urandom_range(0, 31)), $urandom());
      end
      cur_tag = "R7";
      for (int a = 0; a < 6; a++) access(0, 8'(4*a), 32'h0);
      idle(3);
      summary();
      $finish;
   end

endmodule